// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block models the target side of a three-wire serial EEPROM, organised as 256 words of 16 bits. Internally it runs on a fast system clock. The serial clock, chip select and data input are synchronised into that clock domain. Each rising edge of the serial clock is detected there and handled as one bus event. A host selects the device, sends a start bit, a two-bit opcode, an eight-bit address and, when the instruction needs it, sixteen data bits. The block then reads, programs or erases words, or switches its write-enable latch.

Programming is self-timed. Its length in system clocks is set by three parameters: one for single-word write or erase, one for erase-all and one for write-all. A program cycle started by a complete instruction runs to its end even if chip select drops. A host that lowers chip select and raises it again can poll the busy/ready state on the data output. The output has a separate enable so that it can be tri-stated.

Top module: `uw_eeprom`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear and every word reads 0xFFFF.
- R2: The start bit is the first serial-clock rising edge that sees chip select and data-in both high. Earlier edges with data-in low have no effect.
- R3: After the start bit the block takes two opcode bits, then eight address bits MSB first, then sixteen data bits MSB first where needed. The opcodes are 10 = read, 01 = write, 11 = erase and 00 = special. For special, the top two address bits select 11 = enable programming, 00 = disable, 10 = erase-all and 01 = write-all.
- R4: A read drives the enable high and outputs a 0 after the last address bit. It then outputs the addressed word MSB first, one bit per rising serial-clock edge. Further edges continue with the next address, and address 255 wraps to 0.
- R5: A write with programming enabled stores the sixteen data bits at the addressed word.
- R6: Erase sets the addressed word to 0xFFFF. Erase-all sets every word to 0xFFFF.
- R7: Write-all stores its sixteen data bits in every word.
- R8: Write, erase, erase-all and write-all leave the array unchanged unless an enable instruction has run and no disable instruction has run since.
- R9: An instruction cut short by chip select going low has no effect. After the last required bit, further edges are ignored until chip select goes low.
- R10: A program cycle keeps the block busy for its parameter's number of system clocks, and runs to completion with chip select low. While the block is busy, start bits are ignored.
- R11: When chip select is raised after a program cycle has begun, the enable goes high and data-out shows 0 while busy and 1 once ready. If chip select stays low, the enable stays low.
- R12: The enable is low whenever chip select is low, and outside read output and status display.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out / ready status |
| do_oe | output | 1 | Output enable for do_o |

## Verification
Status polling and the expiry of the program timer can fall in the same system cycle: the host is watching data-out at the moment the busy counter reaches zero. The bench provokes this by re-raising chip select right after a write completes. It also clocks a full start bit and read header into the busy block, which must leave the status display in place. It then samples data-out on every system clock until it turns high, and requires the low-to-high change to come no later than the write time plus a small synchroniser margin.

// File: rtl/uw_pkg.sv
package uw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_RD,
        ST_DONE
    } uw_state_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_ERASE = 2'b11;
    localparam logic [1:0] OP_SPEC  = 2'b00;

    localparam logic [1:0] SP_EN    = 2'b11;
    localparam logic [1:0] SP_DIS   = 2'b00;
    localparam logic [1:0] SP_ERALL = 2'b10;
    localparam logic [1:0] SP_WRALL = 2'b01;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise
);
    logic [2:0] chain_q [STAGES];
    logic       sk_prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= '0;
                else        chain_q[0] <= {cs, sk, di};
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= '0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_prev_q <= 1'b0;
        else        sk_prev_q <= chain_q[STAGES-1][1];
    end

    assign cs_s    = chain_q[STAGES-1][2];
    assign di_s    = chain_q[STAGES-1][0];
    assign sk_rise = chain_q[STAGES-1][1] & ~sk_prev_q;
endmodule

// File: rtl/uw_timer.sv
module uw_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = load;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && load != '0) |=> busy);
    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt_q) == 1 && !$past(start)));
endmodule

// File: rtl/uw_array.sv
module uw_array #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_one,
    input  logic          we_all,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_all) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= wdata;
        end else if (we_one) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/uw_eeprom.sv
module uw_eeprom #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int SYNC_N  = 2,
    parameter int T_WR    = 250000,
    parameter int T_ERAL  = 750000,
    parameter int T_WRAL  = 1875000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic do_o,
    output logic do_oe
);
    import uw_pkg::*;

    localparam int T_MAX = (T_WRAL > T_ERAL) ? ((T_WRAL > T_WR) ? T_WRAL : T_WR)
                                             : ((T_ERAL > T_WR) ? T_ERAL : T_WR);
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam int BIT_W = $clog2(DATA_W + 1);

    typedef struct packed {
        uw_state_e          st;
        logic [BIT_W-1:0]   cnt;
        logic [1:0]         opc;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  data;
        logic [DATA_W-1:0]  sh;
        logic               dout;
        logic               wren;
        logic               stat;
    } uw_regs_t;

    uw_regs_t d, q;

    logic              cs_s, di_s, sk_rise, busy;
    logic              we_one, we_all, prog_go;
    logic [CNT_W-1:0]  prog_len;
    logic [ADDR_W-1:0] waddr, raddr, a_full;
    logic [DATA_W-1:0] wdata, rdata, d_full;

    uw_sync #(.STAGES(SYNC_N)) i_sync (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .cs_s(cs_s), .di_s(di_s), .sk_rise(sk_rise)
    );

    uw_timer #(.CNT_W(CNT_W)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_go), .load(prog_len), .busy(busy)
    );

    uw_array #(.AW(ADDR_W), .DW(DATA_W)) i_array (
        .clk(clk), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
    );

    assign a_full = {q.addr[ADDR_W-2:0], di_s};
    assign d_full = {q.data[DATA_W-2:0], di_s};
    assign raddr  = (q.st == ST_RD) ? q.addr + 1'b1 : a_full;

    always_comb begin
        d        = q;
        we_one   = 1'b0;
        we_all   = 1'b0;
        prog_go  = 1'b0;
        prog_len = '0;
        waddr    = q.addr;
        wdata    = '1;
        if (!cs_s) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else if (sk_rise) begin
            unique case (q.st)
                ST_IDLE: if (di_s && !busy) begin
                    d.st   = ST_OPC;
                    d.cnt  = '0;
                    d.stat = 1'b0;
                end
                ST_OPC: begin
                    d.opc = {q.opc[0], di_s};
                    if (q.cnt == 1) begin
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                    end else d.cnt = q.cnt + 1'b1;
                end
                ST_ADDR: begin
                    d.addr = a_full;
                    if (q.cnt == BIT_W'(ADDR_W - 1)) begin
                        d.cnt = '0;
                        d.st  = ST_DONE;
                        unique case (q.opc)
                            OP_READ: begin
                                d.st   = ST_RD;
                                d.sh   = rdata;
                                d.dout = 1'b0;
                            end
                            OP_WRITE: d.st = ST_DATA;
                            OP_ERASE: if (q.wren) begin
                                we_one   = 1'b1;
                                waddr    = a_full;
                                prog_go  = 1'b1;
                                prog_len = CNT_W'(T_WR);
                                d.stat   = 1'b1;
                            end
                            default: begin
                                unique case (a_full[ADDR_W-1 -: 2])
                                    SP_EN:  d.wren = 1'b1;
                                    SP_DIS: d.wren = 1'b0;
                                    SP_ERALL: if (q.wren) begin
                                        we_all   = 1'b1;
                                        prog_go  = 1'b1;
                                        prog_len = CNT_W'(T_ERAL);
                                        d.stat   = 1'b1;
                                    end
                                    default: d.st = ST_DATA;
                                endcase
                            end
                        endcase
                    end else d.cnt = q.cnt + 1'b1;
                end
                ST_DATA: begin
                    d.data = d_full;
                    if (q.cnt == BIT_W'(DATA_W - 1)) begin
                        d.st  = ST_DONE;
                        d.cnt = '0;
                        if (q.wren) begin
                            wdata    = d_full;
                            prog_go  = 1'b1;
                            d.stat   = 1'b1;
                            if (q.opc == OP_WRITE) begin
                                we_one   = 1'b1;
                                prog_len = CNT_W'(T_WR);
                            end else begin
                                we_all   = 1'b1;
                                prog_len = CNT_W'(T_WRAL);
                            end
                        end
                    end else d.cnt = q.cnt + 1'b1;
                end
                ST_RD: begin
                    d.dout = q.sh[DATA_W-1];
                    d.sh   = {q.sh[DATA_W-2:0], 1'b0};
                    if (q.cnt == BIT_W'(DATA_W - 1)) begin
                        d.cnt  = '0;
                        d.addr = q.addr + 1'b1;
                        d.sh   = rdata;
                    end else d.cnt = q.cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign do_oe = cs_s && ((q.st == ST_RD) || (q.st == ST_IDLE && q.stat));
    assign do_o  = (q.st == ST_RD) ? q.dout : ~busy;

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> !busy);
    // R8
    prog_needs_wren_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.wren));
    // R4
    rd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD && $past(q.st) != ST_RD) |-> $past(q.st) == ST_ADDR);
    // R12
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st inside {ST_OPC, ST_ADDR, ST_DATA, ST_DONE}) |-> !do_oe);
endmodule

// File: tb/test_uw_eeprom.sv
module test_uw_eeprom;
    localparam int TW  = 200;
    localparam int TEA = 300;
    localparam int TWA = 400;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic do_o, do_oe;
    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    uw_eeprom #(.T_WR(TW), .T_ERAL(TEA), .T_WRAL(TWA)) i_uw_eeprom (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .do_o(do_o), .do_oe(do_oe)
    );

    localparam logic [23:0] VEC [4] = '{
        {8'h00, 16'h1234}, {8'h7F, 16'hBEEF},
        {8'hFF, 16'h0001}, {8'h80, 16'hA5C3}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic b);
        @(negedge clk) di = b;
        repeat (3) @(negedge clk);
        sk = 1'b1;
        repeat (6) @(negedge clk);
        sk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    task automatic cs_up();
        @(negedge clk) cs = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk) begin cs = 1'b0; di = 1'b0; end
        repeat (6) @(negedge clk);
    endtask

    task automatic instr(input logic [1:0] op, input logic [7:0] a);
        pulse(1'b1);
        send({30'd0, op}, 2);
        send({24'd0, a}, 8);
    endtask

    task automatic settle();
        repeat (TWA + 20) @(negedge clk);
    endtask

    task automatic prog(input logic [1:0] op, input logic [7:0] a, input bit with_data, input logic [15:0] v);
        cs_up();
        instr(op, a);
        if (with_data) send({16'd0, v}, 16);
        cs_down();
        settle();
    endtask

    task automatic rd_word(output logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            pulse(1'b0);
            w[i] = do_o;
        end
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] w;
        cs_up();
        instr(2'b10, a);
        chk(do_oe === 1'b1 && do_o === 1'b0, {tag, " dummy"}, {do_oe, do_o}, 32'h2);
        rd_word(w);
        chk(w === exp, tag, w, exp);
        cs_down();
    endtask

    initial begin
        repeat (2000000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int          waited;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(do_oe === 1'b0, "R1 R12 reset oe", do_oe, 0);

        // R8 R1: write before enabling has no effect
        prog(2'b01, 8'h05, 1'b1, 16'h0000);
        read_chk(8'h05, 16'hFFFF, "R8 R1 write while disabled");

        // R3: enable programming (special, top address bits 11)
        prog(2'b00, 8'hC0, 1'b0, 16'h0);

        // R5 R3: table-driven write then read back
        foreach (VEC[k]) prog(2'b01, VEC[k][23:16], 1'b1, VEC[k][15:0]);
        foreach (VEC[k]) read_chk(VEC[k][23:16], VEC[k][15:0], "R5 R3 write/read");

        // R2: leading clocks with di low, then start
        cs_up();
        send(32'd0, 5);
        instr(2'b10, 8'h7F);
        chk(do_oe === 1'b1 && do_o === 1'b0, "R2 dummy after idle clocks", {do_oe, do_o}, 2);
        rd_word(w);
        chk(w === 16'hBEEF, "R2 read after idle clocks", w, 16'hBEEF);
        cs_down();

        // R4: sequential read wraps from 255 to 0
        cs_up();
        instr(2'b10, 8'hFF);
        rd_word(w);
        chk(w === 16'h0001, "R4 seq word 255", w, 16'h0001);
        rd_word(w);
        chk(w === 16'h1234, "R4 seq wrap to 0", w, 16'h1234);
        chk(do_oe === 1'b1, "R4 oe during read", do_oe, 1);
        cs_down();
        chk(do_oe === 1'b0, "R12 oe after cs low", do_oe, 0);

        // R11 R10: status poll racing timer expiry, start ignored while busy
        cs_up();
        instr(2'b01, 8'h10);
        send(32'h0000_C0DE, 16);
        chk(do_oe === 1'b0, "R9 R12 oe after last bit", do_oe, 0);
        cs_down();
        cs_up();
        chk(do_oe === 1'b1 && do_o === 1'b0, "R11 busy status", {do_oe, do_o}, 2);
        instr(2'b10, 8'h10);
        chk(do_oe === 1'b1 && do_o === 1'b0, "R10 start ignored while busy", {do_oe, do_o}, 2);
        waited = 0;
        while (do_o !== 1'b1 && waited < TW + 20) begin
            @(negedge clk);
            waited++;
        end
        chk(do_o === 1'b1 && do_oe === 1'b1, "R10 R11 ready within write time", {do_oe, do_o}, 3);
        cs_down();
        read_chk(8'h10, 16'hC0DE, "R10 write landed");

        // R11 R10: cs low for whole cycle, no drive, write still completes
        cs_up();
        instr(2'b01, 8'h11);
        send(32'h0000_7777, 16);
        cs_down();
        repeat (20) @(negedge clk);
        chk(do_oe === 1'b0, "R11 oe with cs low while busy", do_oe, 0);
        settle();
        read_chk(8'h11, 16'h7777, "R10 completes with cs low");

        // R9: aborted write and trailing clocks
        cs_up();
        instr(2'b01, 8'h00);
        send(32'h0000_00AA, 8);
        cs_down();
        settle();
        read_chk(8'h00, 16'h1234, "R9 aborted write");
        cs_up();
        instr(2'b11, 8'h12);
        instr(2'b10, 8'h00);
        chk(do_oe === 1'b0, "R9 bits after instruction ignored", do_oe, 0);
        cs_down();
        settle();

        // R6: single erase
        prog(2'b11, 8'h7F, 1'b0, 16'h0);
        read_chk(8'h7F, 16'hFFFF, "R6 erase word");

        // R8: disable then write ignored
        prog(2'b00, 8'h00, 1'b0, 16'h0);
        prog(2'b01, 8'h80, 1'b1, 16'h0000);
        read_chk(8'h80, 16'hA5C3, "R8 write after disable");

        // R7: write-all
        prog(2'b00, 8'hC0, 1'b0, 16'h0);
        prog(2'b00, 8'h40, 1'b1, 16'h5A5A);
        read_chk(8'h00, 16'h5A5A, "R7 write-all low");
        read_chk(8'hFF, 16'h5A5A, "R7 write-all high");

        // R6: erase-all
        prog(2'b00, 8'h80, 1'b0, 16'h0);
        read_chk(8'h33, 16'hFFFF, "R6 erase-all");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule